// File: doc/BRIEF.md
# Shared Interrupt Target Router

This block decides, for each CPU of an interrupt distributor, whether that CPU has at least one interrupt it should take. Every shared interrupt (index 32 and above) carries a target byte in which bit c routes the interrupt to CPU c. The block stores these bytes. It keeps one route bitmap per CPU, indexed by (interrupt - 32). It combines the routes with the enable and pending vectors into a registered per-CPU pending vector. Priority plays no part in the decision. Delivering interrupts to the CPU interfaces is left to other logic.

Target bytes arrive on a valid/ready stream. Once a byte has been accepted, the block uses the next cycle to rebuild the route bitmaps from the whole stored target table, and ready is low during that cycle. A producer must hold `tgt_wr_valid` and its payload until it sees ready high at a clock edge. The rebuild refreshes only the bitmaps of CPUs that are online at that moment. A CPU brought online later keeps its old routes until the next target write. Between rebuilds, the pending vector is recomputed only when the distributor pulses `state_chg_i`. It is held at zero while the distributor enable is low.

Top module: `irq_target_router`

## Requirements
- R1: `tgt_wr_ready` is high after reset and whenever no rebuild is under way. A write is accepted in a cycle where valid and ready are both high. In the cycle after an acceptance, ready is low for exactly one cycle and then returns high.
- R2: After the rebuild that follows a write of byte B to shared interrupt i, let CPU c be online with c < NUM_CPU. Shared interrupt i, enabled and pending, sets `pend_o[c]` when bit c of B is 1 and does not set it when bit c of B is 0. Bits of B at or above NUM_CPU have no effect.
- R3: A target write addressed to an interrupt below 32 is accepted and causes a rebuild, but it changes no route.
- R4: A rebuild updates only the route bitmaps of CPUs whose index is below `online_i` at the rebuild edge. Route bitmaps never change in any other cycle. An offline CPU's routes stay stale until a later rebuild that happens while it is online.
- R5: CPU c is flagged pending when any bit of its private bank (bits 32c..32c+31 of the private vectors) is both enabled and pending, with no route involved.
- R6: An interrupt counts only when its enable bit and its pending bit are both 1.
- R7: When `dist_en_i` is high and `state_chg_i` is sampled high, `pend_o` takes the newly computed value at that edge and is visible one cycle later. With no pulse and no rebuild, `pend_o` holds its value even if the inputs change.
- R8: In the cycle after `dist_en_i` is sampled low, `pend_o` is all zeros, and it stays zero until a later recompute with the enable high.
- R9: Bits of `pend_o` at indices at or above `online_i` (as sampled at the recompute edge) are zero.
- R10: The rebuild edge also recomputes `pend_o`, using the freshly rebuilt routes, so the new routing is visible in the cycle after the rebuild cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_wr_valid | input | 1 | Target byte write valid |
| tgt_wr_ready | output | 1 | Low during the rebuild cycle |
| tgt_wr_irq | input | $clog2(NUM_IRQ) | Interrupt index of the write |
| tgt_wr_byte | input | 8 | Target byte, bit c selects CPU c |
| online_i | input | $clog2(NUM_CPU+1) | Number of online CPUs |
| dist_en_i | input | 1 | Distributor global enable |
| state_chg_i | input | 1 | Pulse: distributor state changed, recompute |
| priv_en_i | input | NUM_CPU*32 | Private bank enables, CPU c at bits 32c+31..32c |
| priv_pnd_i | input | NUM_CPU*32 | Private bank pending, same layout |
| spi_en_i | input | NUM_IRQ-32 | Shared enables, bit i-32 for interrupt i |
| spi_pnd_i | input | NUM_IRQ-32 | Shared pending, same layout |
| pend_o | output | NUM_CPU | Per-CPU has-pending-interrupt flags |

## Verification
The hardest case to reach is a stale route. It needs a target write while a CPU is offline, then the CPU brought online, then a recompute without any further write. The bench lowers the online count, rewrites a target that already had a known value, raises the count, and pulses a recompute with only that interrupt pending. The expected result still carries the old routing for the upper CPUs. A second write to an unrelated interrupt then has to refresh the stale bitmap. An exhaustive sweep over all 32 shared interrupts, with target bytes that include bits beyond the CPU count, covers the normal routing.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int PRIV_IRQS = 32;
  localparam int MAX_CPUS  = 8;
  typedef logic [7:0] tgt_byte_t;
endpackage

// File: rtl/irq_tgt_store.sv
// Target byte table for shared interrupts plus the write handshake.
module irq_tgt_store
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  localparam int NUM_SPI = NUM_IRQ - PRIV_IRQS,
  localparam int IW = $clog2(NUM_IRQ)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_valid,
  output logic                            wr_ready,
  input  logic [IW-1:0]                   wr_irq,
  input  tgt_byte_t                       wr_byte,
  output logic                            rebuild_o,
  output logic [NUM_SPI-1:0][NUM_CPU-1:0] tgt_o
);
  logic          busy_q;
  logic          accept;
  logic          is_shared;
  logic [IW-1:0] spi_idx;

  assign wr_ready  = !busy_q;
  assign accept    = wr_valid && wr_ready;
  assign is_shared = (wr_irq >= IW'(PRIV_IRQS));
  assign spi_idx   = wr_irq - IW'(PRIV_IRQS);
  assign rebuild_o = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= accept;
  end

  for (genvar s = 0; s < NUM_SPI; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        tgt_o[s] <= '0;
      else if (accept && is_shared && (spi_idx == IW'(s)))
        tgt_o[s] <= wr_byte[NUM_CPU-1:0];
    end
  end
endmodule

// File: rtl/irq_route_build.sv
// Per-CPU route bitmaps, refreshed from the target table on rebuild only.
module irq_route_build
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  localparam int NUM_SPI = NUM_IRQ - PRIV_IRQS,
  localparam int CW = $clog2(NUM_CPU + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rebuild_i,
  input  logic [CW-1:0]                   online_i,
  input  logic [NUM_SPI-1:0][NUM_CPU-1:0] tgt_i,
  output logic [NUM_CPU-1:0][NUM_SPI-1:0] route_d,
  output logic [NUM_CPU-1:0][NUM_SPI-1:0] route_q
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SPI-1:0] column;
    logic               online;

    for (genvar s = 0; s < NUM_SPI; s++) begin : g_col
      assign column[s] = tgt_i[s][c];
    end

    assign online     = (CW'(c) < online_i);
    assign route_d[c] = (rebuild_i && online) ? column : route_q[c];

    always_ff @(posedge clk) begin
      if (!rst_n) route_q[c] <= '0;
      else        route_q[c] <= route_d[c];
    end
  end
endmodule

// File: rtl/irq_pend_eval.sv
// Per-CPU pending decision, registered on recompute events.
module irq_pend_eval
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  localparam int NUM_SPI = NUM_IRQ - PRIV_IRQS,
  localparam int CW = $clog2(NUM_CPU + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            dist_en_i,
  input  logic                            recompute_i,
  input  logic [CW-1:0]                   online_i,
  input  logic [NUM_CPU-1:0][NUM_SPI-1:0] route_i,
  input  logic [NUM_CPU-1:0][PRIV_IRQS-1:0] priv_en_i,
  input  logic [NUM_CPU-1:0][PRIV_IRQS-1:0] priv_pnd_i,
  input  logic [NUM_SPI-1:0]              spi_en_i,
  input  logic [NUM_SPI-1:0]              spi_pnd_i,
  output logic [NUM_CPU-1:0]              pend_o
);
  logic [NUM_SPI-1:0] spi_live;
  logic [NUM_CPU-1:0] hit;

  assign spi_live = spi_en_i & spi_pnd_i;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic priv_hit, spi_hit;
    assign priv_hit = |(priv_en_i[c] & priv_pnd_i[c]);
    assign spi_hit  = |(spi_live & route_i[c]);
    assign hit[c]   = (CW'(c) < online_i) && (priv_hit || spi_hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          pend_o <= '0;
    else if (!dist_en_i) pend_o <= '0;
    else if (recompute_i) pend_o <= hit;
  end
endmodule

// File: rtl/irq_target_router.sv
module irq_target_router
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  localparam int NUM_SPI = NUM_IRQ - PRIV_IRQS,
  localparam int IW = $clog2(NUM_IRQ),
  localparam int CW = $clog2(NUM_CPU + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tgt_wr_valid,
  output logic                         tgt_wr_ready,
  input  logic [IW-1:0]                tgt_wr_irq,
  input  logic [7:0]                   tgt_wr_byte,
  input  logic [CW-1:0]                online_i,
  input  logic                         dist_en_i,
  input  logic                         state_chg_i,
  input  logic [NUM_CPU*PRIV_IRQS-1:0] priv_en_i,
  input  logic [NUM_CPU*PRIV_IRQS-1:0] priv_pnd_i,
  input  logic [NUM_SPI-1:0]           spi_en_i,
  input  logic [NUM_SPI-1:0]           spi_pnd_i,
  output logic [NUM_CPU-1:0]           pend_o
);
  initial begin
    if (NUM_CPU < 1 || NUM_CPU > MAX_CPUS) $error("NUM_CPU out of range");
    if (NUM_IRQ <= PRIV_IRQS) $error("NUM_IRQ must exceed the private bank");
  end

  logic                              rebuild;
  logic [NUM_SPI-1:0][NUM_CPU-1:0]   tgt_tab;
  logic [NUM_CPU-1:0][NUM_SPI-1:0]   route_d;
  logic [NUM_CPU-1:0][NUM_SPI-1:0]   route_q;
  logic [NUM_CPU-1:0][PRIV_IRQS-1:0] priv_en_a;
  logic [NUM_CPU-1:0][PRIV_IRQS-1:0] priv_pnd_a;

  assign priv_en_a  = priv_en_i;
  assign priv_pnd_a = priv_pnd_i;

  irq_tgt_store #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (tgt_wr_valid),
    .wr_ready  (tgt_wr_ready),
    .wr_irq    (tgt_wr_irq),
    .wr_byte   (tgt_wr_byte),
    .rebuild_o (rebuild),
    .tgt_o     (tgt_tab)
  );

  irq_route_build #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) route_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rebuild_i (rebuild),
    .online_i  (online_i),
    .tgt_i     (tgt_tab),
    .route_d   (route_d),
    .route_q   (route_q)
  );

  irq_pend_eval #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) eval_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dist_en_i   (dist_en_i),
    .recompute_i (state_chg_i || rebuild),
    .online_i    (online_i),
    .route_i     (route_d),
    .priv_en_i   (priv_en_a),
    .priv_pnd_i  (priv_pnd_a),
    .spi_en_i    (spi_en_i),
    .spi_pnd_i   (spi_pnd_i),
    .pend_o      (pend_o)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  localparam int NUM_SPI = NUM_IRQ - PRIV_IRQS,
  localparam int CW = $clog2(NUM_CPU + 1)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            tgt_wr_valid,
  input logic                            tgt_wr_ready,
  input logic [CW-1:0]                   online_i,
  input logic                            dist_en_i,
  input logic                            state_chg_i,
  input logic [NUM_CPU-1:0]              pend_o,
  input logic [NUM_CPU-1:0][NUM_SPI-1:0] route_q
);
  logic [NUM_CPU-1:0] on_mask;
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_m
    assign on_mask[c] = (CW'(c) < online_i);
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wr_valid && tgt_wr_ready) |=> !tgt_wr_ready);

  a_r1_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_wr_ready |=> tgt_wr_ready);

  a_r4_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_wr_ready |=> $stable(route_q));

  a_r7_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!state_chg_i && tgt_wr_ready && dist_en_i) |=> $stable(pend_o));

  a_r8_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dist_en_i |=> (pend_o == '0));

  a_r9_offline_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_chg_i && dist_en_i) |=> ((pend_o & ~$past(on_mask)) == '0));
endmodule

bind irq_target_router irq_route_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .tgt_wr_valid (tgt_wr_valid),
  .tgt_wr_ready (tgt_wr_ready),
  .online_i     (online_i),
  .dist_en_i    (dist_en_i),
  .state_chg_i  (state_chg_i),
  .pend_o       (pend_o),
  .route_q      (route_q)
);

// File: tb/irq_target_router_tb_top.sv
`timescale 1ns/1ps
module irq_target_router_tb_top;
  localparam int NI = 64;
  localparam int NC = 4;
  localparam int NS = NI - 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tgt_wr_valid = 1'b0;
  logic           tgt_wr_ready;
  logic [5:0]     tgt_wr_irq = '0;
  logic [7:0]     tgt_wr_byte = '0;
  logic [2:0]     online_i = 3'd4;
  logic           dist_en_i = 1'b1;
  logic           state_chg_i = 1'b0;
  logic [NC*32-1:0] priv_en_i = '0;
  logic [NC*32-1:0] priv_pnd_i = '0;
  logic [NS-1:0]  spi_en_i = '0;
  logic [NS-1:0]  spi_pnd_i = '0;
  logic [NC-1:0]  pend_o;

  irq_target_router #(.NUM_IRQ(NI), .NUM_CPU(NC)) dut_i (.*);

  always #10 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  logic [NC-1:0] tgt_m [NS];
  logic [NS-1:0] route_m [NC];
  logic [NC-1:0] pend_m = '0;

  function automatic logic [NC-1:0] calc();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++) begin
      if (c < int'(online_i) && dist_en_i)
        r[c] = |(priv_en_i[c*32 +: 32] & priv_pnd_i[c*32 +: 32]) ||
               |(spi_en_i & spi_pnd_i & route_m[c]);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) state_chg_i = 1'b1;
    @(negedge clk) state_chg_i = 1'b0;
    pend_m = dist_en_i ? calc() : '0;
  endtask

  task automatic write_tgt(input int irq, input logic [7:0] b, input string tag);
    @(negedge clk);
    tgt_wr_valid = 1'b1; tgt_wr_irq = 6'(irq); tgt_wr_byte = b;
    check("R1 ready idle", 32'(tgt_wr_ready), 32'd1);
    @(negedge clk);
    tgt_wr_valid = 1'b0;
    if (irq >= 32) tgt_m[irq-32] = b[NC-1:0];
    check("R1 ready low in rebuild", 32'(tgt_wr_ready), 32'd0);
    @(negedge clk);
    check("R1 ready back", 32'(tgt_wr_ready), 32'd1);
    for (int c = 0; c < NC; c++)
      if (c < int'(online_i))
        for (int s = 0; s < NS; s++) route_m[c][s] = tgt_m[s][c];
    pend_m = dist_en_i ? calc() : '0;
    check(tag, 32'(pend_o), 32'(pend_m));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected <= 50000", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) tgt_m[s] = '0;
    for (int c = 0; c < NC; c++) route_m[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset pend", 32'(pend_o), 32'd0);
    check("R1 reset ready", 32'(tgt_wr_ready), 32'd1);

    // R2: exhaustive target sweep, bytes carry bits above NUM_CPU; R10 checked on each rebuild
    spi_en_i = '1;
    for (int s = 0; s < NS; s++) write_tgt(32 + s, 8'((s * 37 + 11) & 255), "R10 rebuild recompute");
    for (int s = 0; s < NS; s++) begin
      spi_pnd_i = NS'(1) << s;
      pulse();
      check("R2 route single", 32'(pend_o), 32'(pend_m));
      check("R2 route vs byte", 32'(pend_o), 32'(8'((s * 37 + 11) & 255) & 8'h0F));
    end

    // R6: enable without pending and pending without enable
    for (int s = 0; s < NS; s++) begin
      spi_en_i = NS'(1) << s;
      spi_pnd_i = ~(NS'(1) << s);
      pulse();
      check("R6 en xor pnd", 32'(pend_o), 32'd0);
    end
    spi_pnd_i = '0;
    spi_en_i = '1;

    // R5: private bank per CPU
    for (int c = 0; c < NC; c++) begin
      for (int k = 0; k < 3; k++) begin
        int b = (k == 0) ? 0 : (k == 1) ? 17 : 31;
        priv_en_i = '0; priv_pnd_i = '0;
        priv_en_i[c*32 + b] = 1'b1;
        priv_pnd_i[c*32 + b] = 1'b1;
        pulse();
        check("R5 private hit", 32'(pend_o), 32'(4'b1 << c));
        priv_pnd_i = '0;
        pulse();
        check("R5 private enable only", 32'(pend_o), 32'd0);
      end
    end
    priv_en_i = '0;

    // R3: writes to the private range change no route
    write_tgt(5, 8'hFF, "R3 private write");
    write_tgt(31, 8'hFF, "R3 private write");
    for (int s = 0; s < NS; s += 5) begin
      spi_pnd_i = NS'(1) << s;
      pulse();
      check("R3 routes unchanged", 32'(pend_o), 32'(8'((s * 37 + 11) & 255) & 8'h0F));
    end

    // R4: stale routes of a CPU that was offline at rebuild
    online_i = 3'd2;
    spi_pnd_i = NS'(1);
    write_tgt(32, 8'h0C, "R10 rebuild two online");
    online_i = 3'd4;
    pulse();
    check("R4 stale route", 32'(pend_o), 32'h8);
    check("R4 stale model", 32'(pend_o), 32'(pend_m));
    write_tgt(33, 8'h00, "R10 rebuild four online");
    check("R4 refreshed route", 32'(pend_o), 32'hC);

    // R9: online count masks upper CPUs
    priv_en_i = '1; priv_pnd_i = '1;
    for (int n = 0; n <= NC; n++) begin
      online_i = 3'(n);
      pulse();
      check("R9 offline zero", 32'(pend_o), 32'((1 << n) - 1));
    end

    // R7: no pulse, no update
    priv_pnd_i = '0; spi_pnd_i = '0;
    repeat (4) @(negedge clk);
    check("R7 hold without pulse", 32'(pend_o), 32'hF);
    pulse();
    check("R7 update after pulse", 32'(pend_o), 32'h0);

    // R8: enable low forces zero
    priv_pnd_i = '1;
    pulse();
    check("R8 before disable", 32'(pend_o), 32'hF);
    dist_en_i = 1'b0;
    @(negedge clk);
    check("R8 disabled zero", 32'(pend_o), 32'h0);
    pulse();
    check("R8 pulse while disabled", 32'(pend_o), 32'h0);
    dist_en_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 stays zero until recompute", 32'(pend_o), 32'h0);
    pulse();
    check("R8 restored", 32'(pend_o), 32'hF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule